// File: doc/BRIEF.md
# Segmented Two-Level Address Translator

This block turns a logical address into a physical address in two stages. A request names one entry of a small on-chip descriptor cache and carries a 32-bit offset. The selected entry supplies a segment base and a segment limit. The base and the offset are added modulo 2^32 to form a linear address. If the offset lies past the limit, the request ends with a protection fault and no address is produced.

When both protection and paging are enabled, the linear address is then mapped through a two-level walk of 4 KB pages. The walk starts at a directory base register and reads one directory entry and one table entry over a synchronous memory read port. If either entry has its present flag clear, the walk stops with a page fault, and the faulting linear address is kept in a fault-address register. When paging is off, or protection is off, the linear address is used as the physical address without any memory read.

The translator takes one request at a time. It reports each result with a one-cycle valid strobe.

Top module: `addr_xlate_top`

## Requirements
- R1: After a synchronous reset, `out_valid`, `out_gp_fault`, `out_pf_fault` and `mem_rd_en` are 0, `fault_lin` is 0 and `req_ready` is 1.
- R2: The linear address is the descriptor base plus the request offset, with the carry out of bit 31 discarded.
- R3: If the offset is greater than the descriptor limit (the limit is the highest valid offset), the result shows `out_gp_fault`=1 and `out_paddr`=0. No memory read is made, and `out_valid` rises on the second rising edge counted from the accepting edge (the accepting edge is edge 1).
- R4: With the paging enable clear, `out_paddr` equals the linear address. No memory read is made, and the result arrives on the second edge.
- R5: With the paging enable set but the protection enable clear, paging has no effect and the result is the same as in R4.
- R6: With both enables set, the block makes exactly two reads. The first read is at {dirbase[31:12], lin[31:22], 2'b00}. The second is at {pde[31:12], lin[21:12], 2'b00}. `out_paddr` is {pte[31:12], lin[11:0]}, and the result arrives on the sixth edge.
- R7: A directory entry whose bit 0 (present) is 0 ends the walk after one read. The result shows `out_pf_fault`=1 and `out_paddr`=0 on the fourth edge, and `fault_lin` takes the linear address.
- R8: A table entry whose bit 0 is 0 ends the walk after two reads. The result shows `out_pf_fault`=1 and `out_paddr`=0 on the sixth edge, and `fault_lin` takes the linear address.
- R9: `fault_lin` changes only together with a page-fault result. Protection faults and good translations leave it unchanged.
- R10: A request is accepted only while `req_ready` is 1. A `req_valid` raised while a translation is in flight is ignored and produces no extra result.
- R11: `out_valid` is high for exactly one cycle per accepted request, and `req_ready` is 1 in that cycle.
- R12: The enables are sampled on the accepting edge. The directory base and the descriptor entries take effect for requests accepted after their write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Write strobe for a descriptor cache entry |
| desc_idx | input | 3 | Descriptor entry written |
| desc_base | input | 32 | Segment base written |
| desc_limit | input | 32 | Highest valid offset written |
| pdbr_we | input | 1 | Write strobe for the directory base register |
| pdbr_in | input | 32 | Directory base; bits 31:12 are kept |
| cfg_pe | input | 1 | Protection enable |
| cfg_pg | input | 1 | Paging enable |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Translator idle, request can be taken |
| req_sel | input | 3 | Descriptor entry used by the request |
| req_off | input | 32 | Offset within the segment |
| mem_rd_en | output | 1 | Read strobe to page-table memory |
| mem_addr | output | 32 | Read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the read edge |
| out_valid | output | 1 | Result strobe |
| out_paddr | output | 32 | Physical address (0 on a fault) |
| out_gp_fault | output | 1 | Limit violation |
| out_pf_fault | output | 1 | Entry not present |
| fault_lin | output | 32 | Linear address of the last page fault |

## Verification
The assertions assume a memory that returns data exactly one cycle after the edge that samples `mem_rd_en`. They also assume that the directory base and the descriptor entries are not rewritten while a walk is in flight. The bench models the memory as a registered function of the address and writes configuration only while `req_ready` is high. It changes the enables only between requests, so the only requests that collide with a busy translator are the deliberate ones in the R10 test.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W   = 32;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 10;
  localparam int ENT_LG   = 2;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t base;
    addr_t limit;
  } seg_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LIN,
    ST_PDE_REQ,
    ST_PDE_DAT,
    ST_PTE_REQ,
    ST_PTE_DAT
  } walk_st_e;

  // Entry address: frame of the level above, index scaled by the entry size.
  function automatic addr_t entry_addr(addr_t frame, logic [IDX_W-1:0] idx);
    return {frame[ADDR_W-1:PG_SHIFT], idx, {ENT_LG{1'b0}}};
  endfunction
endpackage

// File: rtl/seg_cache.sv
module seg_cache
  import xlate_pkg::*;
#(
  parameter int NSEG  = 8,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  seg_desc_t        wr_desc,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] rd_idx,
  output seg_desc_t        rd_desc
);
  // Plain array with a registered read so block RAM can be inferred.
  seg_desc_t mem [NSEG];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_desc;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_desc <= mem[rd_idx];
  end
endmodule

// File: rtl/seg_calc.sv
module seg_calc
  import xlate_pkg::*;
(
  input  seg_desc_t desc,
  input  addr_t     off,
  output addr_t     lin,
  output logic      over
);
  // The sum is kept at address width, so the carry out is dropped.
  always_comb begin
    lin  = desc.base + off;
    over = (off > desc.limit);
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pdbr_we,
  input  addr_t pdbr_in,
  input  logic  cfg_pe,
  input  logic  cfg_pg,
  input  logic  req_valid,
  output logic  req_ready,
  input  addr_t req_off,
  output logic  accept,
  output addr_t off_q,
  input  addr_t lin_i,
  input  logic  over_i,
  output logic  mem_rd_en,
  output addr_t mem_addr,
  input  addr_t mem_rdata,
  output logic  out_valid,
  output addr_t out_paddr,
  output logic  out_gp_fault,
  output logic  out_pf_fault,
  output addr_t fault_lin
);
  localparam int FRAME_W = ADDR_W - PG_SHIFT;
  localparam int DIR_LO  = PG_SHIFT + IDX_W;

  walk_st_e             state;
  logic [FRAME_W-1:0]   dirbase_q;
  logic                 walk_q;
  addr_t                lin_q;
  logic                 present;
  logic                 unused_bits;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign present     = mem_rdata[0];
  assign unused_bits = ^{pdbr_in[PG_SHIFT-1:0], mem_rdata[PG_SHIFT-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      dirbase_q    <= '0;
      walk_q       <= 1'b0;
      off_q        <= '0;
      lin_q        <= '0;
      mem_rd_en    <= 1'b0;
      mem_addr     <= '0;
      out_valid    <= 1'b0;
      out_paddr    <= '0;
      out_gp_fault <= 1'b0;
      out_pf_fault <= 1'b0;
      fault_lin    <= '0;
    end else begin
      out_valid    <= 1'b0;
      out_gp_fault <= 1'b0;
      out_pf_fault <= 1'b0;
      mem_rd_en    <= 1'b0;
      if (pdbr_we) dirbase_q <= pdbr_in[ADDR_W-1:PG_SHIFT];

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            off_q  <= req_off;
            walk_q <= cfg_pe && cfg_pg;
            state  <= ST_LIN;
          end
        end
        ST_LIN: begin
          lin_q <= lin_i;
          if (over_i) begin
            out_valid    <= 1'b1;
            out_gp_fault <= 1'b1;
            out_paddr    <= '0;
            state        <= ST_IDLE;
          end else if (walk_q) begin
            mem_rd_en <= 1'b1;
            mem_addr  <= entry_addr({dirbase_q, {PG_SHIFT{1'b0}}},
                                    lin_i[ADDR_W-1:DIR_LO]);
            state     <= ST_PDE_REQ;
          end else begin
            out_valid <= 1'b1;
            out_paddr <= lin_i;
            state     <= ST_IDLE;
          end
        end
        ST_PDE_REQ: state <= ST_PDE_DAT;
        ST_PDE_DAT: begin
          if (!present) begin
            out_valid    <= 1'b1;
            out_pf_fault <= 1'b1;
            out_paddr    <= '0;
            fault_lin    <= lin_q;
            state        <= ST_IDLE;
          end else begin
            mem_rd_en <= 1'b1;
            mem_addr  <= entry_addr(mem_rdata, lin_q[DIR_LO-1:PG_SHIFT]);
            state     <= ST_PTE_REQ;
          end
        end
        ST_PTE_REQ: state <= ST_PTE_DAT;
        ST_PTE_DAT: begin
          out_valid <= 1'b1;
          state     <= ST_IDLE;
          if (!present) begin
            out_pf_fault <= 1'b1;
            out_paddr    <= '0;
            fault_lin    <= lin_q;
          end else begin
            out_paddr <= {mem_rdata[ADDR_W-1:PG_SHIFT], lin_q[PG_SHIFT-1:0]};
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import xlate_pkg::*;
#(
  parameter int NSEG  = 8,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             desc_we,
  input  logic [SEL_W-1:0] desc_idx,
  input  logic [31:0]      desc_base,
  input  logic [31:0]      desc_limit,
  input  logic             pdbr_we,
  input  logic [31:0]      pdbr_in,
  input  logic             cfg_pe,
  input  logic             cfg_pg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [31:0]      req_off,
  output logic             mem_rd_en,
  output logic [31:0]      mem_addr,
  input  logic [31:0]      mem_rdata,
  output logic             out_valid,
  output logic [31:0]      out_paddr,
  output logic             out_gp_fault,
  output logic             out_pf_fault,
  output logic [31:0]      fault_lin
);
  seg_desc_t wr_desc, rd_desc;
  addr_t     off_q, lin;
  logic      over, accept;

  assign wr_desc = '{base: desc_base, limit: desc_limit};

  seg_cache #(.NSEG(NSEG)) u_cache (
    .clk    (clk),
    .wr_en  (desc_we),
    .wr_idx (desc_idx),
    .wr_desc(wr_desc),
    .rd_en  (accept),
    .rd_idx (req_sel),
    .rd_desc(rd_desc)
  );

  seg_calc u_calc (
    .desc(rd_desc),
    .off (off_q),
    .lin (lin),
    .over(over)
  );

  xlate_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .pdbr_we     (pdbr_we),
    .pdbr_in     (pdbr_in),
    .cfg_pe      (cfg_pe),
    .cfg_pg      (cfg_pg),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_off     (req_off),
    .accept      (accept),
    .off_q       (off_q),
    .lin_i       (lin),
    .over_i      (over),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rdata   (mem_rdata),
    .out_valid   (out_valid),
    .out_paddr   (out_paddr),
    .out_gp_fault(out_gp_fault),
    .out_pf_fault(out_pf_fault),
    .fault_lin   (fault_lin)
  );
endmodule

// File: rtl/xlate_sva.sv
module xlate_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        mem_rd_en,
  input logic        out_valid,
  input logic [31:0] out_paddr,
  input logic        out_gp_fault,
  input logic        out_pf_fault,
  input logic [31:0] fault_lin
);
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_ready_at_result_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> req_ready);

  p_gp_clean_r3: assert property (@(posedge clk) disable iff (rst)
    out_gp_fault |-> (out_valid && !out_pf_fault && out_paddr == 32'd0));

  p_pf_clean_r7: assert property (@(posedge clk) disable iff (rst)
    out_pf_fault |-> (out_valid && out_paddr == 32'd0));

  p_read_single_r6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (!mem_rd_en && !out_valid));

  p_busy_on_read_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  p_flt_only_pf_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_lin) |-> (out_valid && out_pf_fault));
endmodule

bind addr_xlate_top xlate_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .mem_rd_en   (mem_rd_en),
  .out_valid   (out_valid),
  .out_paddr   (out_paddr),
  .out_gp_fault(out_gp_fault),
  .out_pf_fault(out_pf_fault),
  .fault_lin   (fault_lin)
);

// File: tb/test_addr_xlate_top.sv
`timescale 1ns/1ps
module test_addr_xlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_we = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [31:0] desc_base = '0, desc_limit = '0;
  logic        pdbr_we = 1'b0;
  logic [31:0] pdbr_in = '0;
  logic        cfg_pe = 1'b0, cfg_pg = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_sel = '0;
  logic [31:0] req_off = '0;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        out_valid;
  logic [31:0] out_paddr;
  logic        out_gp_fault, out_pf_fault;
  logic [31:0] fault_lin;

  int total = 0, bad = 0;
  bit done = 0;
  int total_reads = 0;
  logic [31:0] rlog [256];
  logic [31:0] kill_a = 32'hFFFF_FFFF;
  logic [31:0] tb_base [8];
  logic [31:0] tb_lim  [8];
  logic [31:0] tb_dir  = '0;
  logic [31:0] flin_exp = '0;

  always #2.5 clk = ~clk;

  addr_xlate_top i_addr_xlate_top (
    .clk(clk), .rst(rst), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_base(desc_base), .desc_limit(desc_limit), .pdbr_we(pdbr_we),
    .pdbr_in(pdbr_in), .cfg_pe(cfg_pe), .cfg_pg(cfg_pg),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_off(req_off), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_paddr(out_paddr),
    .out_gp_fault(out_gp_fault), .out_pf_fault(out_pf_fault),
    .fault_lin(fault_lin)
  );

  // Page-table memory: a hashed word per address, bit 0 is present.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] h;
    logic        p;
    h = a * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    p = (a == kill_a) ? 1'b0 : (h[7:5] != 3'd0);
    return {h[31:12], 11'd0, p};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= mem_word(mem_addr);
      rlog[total_reads[7:0]] <= mem_addr;
      total_reads <= total_reads + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic wr_desc(input int i, input logic [31:0] b, input logic [31:0] l);
    @(negedge clk);
    desc_we = 1; desc_idx = 3'(i); desc_base = b; desc_limit = l;
    tb_base[i] = b; tb_lim[i] = l;
    @(negedge clk);
    desc_we = 0;
  endtask

  task automatic wr_dir(input logic [31:0] d);
    @(negedge clk);
    pdbr_we = 1; pdbr_in = d; tb_dir = d;
    @(negedge clk);
    pdbr_we = 0;
  endtask

  // Reference model written from the requirements.
  task automatic model(input int sel, input logic [31:0] off, input bit pe, input bit pg,
                       output logic [31:0] pa, output bit gp, output bit pf,
                       output int nrd, output int lat, output logic [31:0] a0,
                       output logic [31:0] a1, output string tag);
    logic [31:0] lin, d, t;
    lin = tb_base[sel] + off;
    pa = 0; gp = 0; pf = 0; nrd = 0; lat = 2; a0 = 0; a1 = 0;
    if (off > tb_lim[sel]) begin
      gp = 1; tag = "R3";
    end else if (!(pe && pg)) begin
      pa = lin; tag = pg ? "R5" : "R4";
    end else begin
      a0 = {tb_dir[31:12], lin[31:22], 2'b00};
      d = mem_word(a0); nrd = 1; lat = 4;
      if (!d[0]) begin
        pf = 1; tag = "R7";
      end else begin
        a1 = {d[31:12], lin[21:12], 2'b00};
        t = mem_word(a1); nrd = 2; lat = 6;
        if (!t[0]) begin pf = 1; tag = "R8"; end
        else begin pa = {t[31:12], lin[11:0]}; tag = "R6"; end
      end
    end
    if (pf) flin_exp = lin;
  endtask

  task automatic do_req(input int sel, input logic [31:0] off, input bit noise);
    logic [31:0] pa, a0, a1;
    bit gp, pf;
    int nrd, lat, start, seen, cnt;
    string tag;
    model(sel, off, cfg_pe, cfg_pg, pa, gp, pf, nrd, lat, a0, a1, tag);
    start = total_reads;
    @(negedge clk);
    req_valid = 1; req_sel = 3'(sel); req_off = off;
    @(posedge clk);
    seen = 0;
    while (1) begin
      @(negedge clk);
      seen++;
      if (noise) begin req_valid = 1; req_sel = ~3'(sel); req_off = ~off; end
      else req_valid = 0;
      if (out_valid || seen > 20) break;
    end
    req_valid = 0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " latency"}, seen, lat);
    check({tag, " paddr"}, out_paddr, pa);
    check({tag, " gp"}, {31'd0, out_gp_fault}, {31'd0, gp});
    check({tag, " pf"}, {31'd0, out_pf_fault}, {31'd0, pf});
    check({tag, " R11 ready"}, {31'd0, req_ready}, 32'd1);
    check({tag, " reads"}, total_reads - start, nrd);
    if (nrd > 0) check({tag, " dir addr"}, rlog[start[7:0]], a0);
    if (nrd > 1) check({tag, " tbl addr"}, rlog[8'(start + 1)], a1);
    check({tag, " R9 fault_lin"}, fault_lin, flin_exp);
    // R11 / R10: no second strobe, even when requests arrived while busy.
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (out_valid) cnt++;
    end
    check(noise ? "R10 no extra result" : "R11 single strobe", cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin tb_base[i] = 0; tb_lim[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 valid", {31'd0, out_valid}, 0);
    check("R1 ready", {31'd0, req_ready}, 1);
    check("R1 rd_en", {31'd0, mem_rd_en}, 0);
    check("R1 flags", {30'd0, out_gp_fault, out_pf_fault}, 0);
    check("R1 fault_lin", fault_lin, 0);

    wr_desc(0, 32'hFFFF_F000, 32'hFFFF_FFFF);
    wr_desc(1, 32'h0001_0000, 32'h0000_0FFF);
    for (int i = 2; i < 8; i++) wr_desc(i, $urandom, (i == 2) ? 32'hFFFF_FFFF : $urandom);
    wr_dir(32'h0040_3ABC);

    // R2 / R4: wrap-around of base plus offset, paging off.
    cfg_pe = 1; cfg_pg = 0;
    do_req(0, 32'h0000_2345, 0);
    check("R2 wrapped sum", out_paddr, 32'h0000_1345);
    // R5: paging set without protection.
    cfg_pe = 0; cfg_pg = 1;
    do_req(1, 32'h0000_0123, 0);
    // R3: limit boundary, at and one past.
    cfg_pe = 1; cfg_pg = 1;
    do_req(1, 32'h0000_0FFF, 0);
    do_req(1, 32'h0000_1000, 0);
    // R6: full walks.
    do_req(2, 32'h1234_5678, 0);
    do_req(2, 32'hABCD_E010, 0);
    // R7: directory entry absent.
    kill_a = {tb_dir[31:12], 10'h1A5, 2'b00};
    do_req(2, {10'h1A5, 22'h0_1234} - tb_base[2], 0);
    // R8: table entry absent.
    kill_a = {mem_word({tb_dir[31:12], 10'h2C3, 2'b00})[31:12], 10'h077, 2'b00};
    if (!mem_word({tb_dir[31:12], 10'h2C3, 2'b00})[0]) kill_a = 32'hFFFF_FFFF;
    do_req(2, {10'h2C3, 10'h077, 12'h9AB} - tb_base[2], 0);
    kill_a = 32'hFFFF_FFFF;
    // R9: a limit fault after a page fault leaves fault_lin alone.
    do_req(1, 32'h0000_2000, 0);
    // R10: request held high while busy.
    do_req(2, 32'h0BAD_F00D, 1);
    // R12: enables sampled at accept, new directory base used by later requests.
    wr_dir(32'h7FFF_F000);
    do_req(2, 32'h0000_4321, 0);

    for (int n = 0; n < 150; n++) begin
      int s;
      logic [31:0] off;
      s = int'($urandom % 8);
      cfg_pe = 1'($urandom); cfg_pg = 1'($urandom);
      if (n % 4 != 3) begin cfg_pe = 1; cfg_pg = 1; end
      case ($urandom % 4)
        0: off = tb_lim[s];
        1: off = tb_lim[s] + 1;
        default: off = $urandom;
      endcase
      if (n % 37 == 0) wr_dir($urandom);
      do_req(s, off, (n % 10) == 5);
    end
    finish_run();
  end
endmodule